// File: doc/BRIEF.md
# PHY Training Mailbox Reader

This block drains a PHY training mailbox through a 16-bit register access port. After a one-cycle `start`, it polls the mailbox status word until a message is waiting. It then reads the message identifier and the message data, and acknowledges the message in two phases. In the first phase it writes 0 to the acknowledge register and polls until the mailbox reports empty. In the second phase it writes 1 to the acknowledge register. It keeps taking messages until it sees one of two terminal identifiers. A completion identifier ends the run with success. A failure identifier ends it with an error. The block does not interpret any other identifier; it treats it as a progress message and goes back for the next one.

Register requests leave on a valid/ready channel. A request, once raised, keeps its address, direction and write data unchanged until `req_ready` is seen high; that is the only back-pressure point. Writes complete at the handshake and expect no response. A read completes when `rsp_valid` arrives; there is no ready on the response, so the PHY side may return it at any time after the handshake. Each of the two empty-flag waits has a bound of `TIMEOUT_CYC` cycles, which ends the run with a timeout. The identifier and data of the last message read stay visible on `last_id` and `last_data`.

Top module: `phy_mbox_reader`

## Requirements
- R1: While reset is applied and after it is released, `done`, `pass`, `timeout`, `busy` and `req_valid` are low until a start is accepted.
- R2: An accepted `start` raises `busy` the next cycle. The first request is then a read of the status register at byte address 0x1A0008 (the 16-bit register index 0xD0004 doubled). Status bit 0 set to 1 means empty and starts another status read; bit 0 set to 0 means a message is waiting.
- R3: When a message is waiting, the block reads the identifier register (0x1A0064), then the data register (0x1A0068), before any acknowledge. The two values appear on `last_id` and `last_data` and are held until the next such read.
- R4: The acknowledge takes this exact order: a write of 0x0000 to 0x1A0062, then status reads until bit 0 reads 1, then a write of 0x0001 to 0x1A0062. The block makes no other writes.
- R5: After the acknowledge of a message with identifier 0x0007 (all 16 bits compared), `done` and `pass` are high for one cycle and `timeout` stays low.
- R6: After the acknowledge of a message with identifier 0x00FF, `done` is high for one cycle with `pass` and `timeout` low.
- R7: After the acknowledge of any other identifier, including 0x0107, the block goes back to polling for a further message and does not raise `done`.
- R8: Each wait on the empty flag is bounded. After `TIMEOUT_CYC` cycles in the wait, a status read that still fails the wait's condition ends the run with `done` and `timeout` high for one cycle and `pass` low.
- R9: `done`, `pass` and `timeout` never stay high longer than one cycle. `busy` is already low in the cycle `done` is high.
- R10: A pending request holds its fields stable until `req_ready`. A `rsp_valid` with no read outstanding is ignored.
- R11: A `start` while `busy` is ignored. A `start` in the cycle `done` is high is accepted and begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to drain the mailbox |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | With `done`: completion identifier seen |
| timeout | output | 1 | With `done`: an empty-flag wait expired |
| last_id | output | 16 | Identifier of the last message read |
| last_data | output | 16 | Data of the last message read |
| req_valid | output | 1 | Register request pending |
| req_ready | input | 1 | PHY side accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | AW | Byte address of the register |
| req_wdata | output | 16 | Write data |
| rsp_valid | input | 1 | Read data returned |
| rsp_rdata | input | 16 | Returned read data |

## Verification
Two things can happen in the same cycle: the `done` pulse that ends one run, and the `start` that begins the next. The bench provokes this by placing two completion messages in the mailbox model. It waits on the falling clock edge until `done` is high, and in that cycle drives `start`. The scoreboard then has to receive a second, separate success result carrying the second message's data, which shows the start was neither lost nor merged into the first run. A further stray response while idle and a start raised mid-run must both leave the result stream unchanged.

// File: rtl/phy_mbox_pkg.sv
package phy_mbox_pkg;
  localparam int unsigned REG_W = 16;
  typedef logic [REG_W-1:0] word_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT_MSG,
    S_GET_ID,
    S_GET_DATA,
    S_ACK_LO,
    S_WAIT_CLR,
    S_ACK_HI
  } seq_state_t;

  typedef enum logic [1:0] {
    FIN_NONE,
    FIN_OK,
    FIN_ERR,
    FIN_TMO
  } fin_t;

  typedef enum logic [1:0] {
    P_IDLE,
    P_REQ,
    P_RSP
  } port_state_t;
endpackage

// File: rtl/phy_mbox_port.sv
module phy_mbox_port
  import phy_mbox_pkg::*;
#(
  parameter int unsigned AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_write,
  input  logic [AW-1:0] go_addr,
  input  word_t         go_wdata,
  output logic          idle,
  output logic          fin,
  output word_t         fin_data,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output word_t         req_wdata,
  input  logic          rsp_valid,
  input  word_t         rsp_rdata
);
  port_state_t   pst;
  logic          wr_q;
  logic [AW-1:0] addr_q;
  word_t         wdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pst     <= P_IDLE;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      case (pst)
        P_IDLE: if (go) begin
          pst     <= P_REQ;
          wr_q    <= go_write;
          addr_q  <= go_addr;
          wdata_q <= go_wdata;
        end
        P_REQ: if (req_ready) pst <= wr_q ? P_IDLE : P_RSP;
        P_RSP: if (rsp_valid) pst <= P_IDLE;
        default: pst <= P_IDLE;
      endcase
    end
  end

  assign idle      = (pst == P_IDLE);
  assign req_valid = (pst == P_REQ);
  assign req_write = wr_q;
  assign req_addr  = addr_q;
  assign req_wdata = wdata_q;
  assign fin       = ((pst == P_REQ) && req_ready && wr_q) || ((pst == P_RSP) && rsp_valid);
  assign fin_data  = rsp_rdata;
endmodule

// File: rtl/phy_mbox_wait_timer.sv
module phy_mbox_wait_timer #(
  parameter int unsigned LIMIT = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);
endmodule

// File: rtl/phy_mbox_seq.sv
module phy_mbox_seq
  import phy_mbox_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter logic [AW-1:0] ST_ADDR  = '0,
  parameter logic [AW-1:0] ACK_ADDR = '0,
  parameter logic [AW-1:0] ID_ADDR  = '0,
  parameter logic [AW-1:0] DAT_ADDR = '0,
  parameter word_t ID_DONE = 16'h0007,
  parameter word_t ID_FAIL = 16'h00FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          port_idle,
  input  logic          port_fin,
  input  word_t         port_data,
  input  logic          expired,
  output logic          go,
  output logic          go_write,
  output logic [AW-1:0] go_addr,
  output word_t         go_wdata,
  output logic          waiting,
  output logic          busy,
  output fin_t          fin_kind,
  output word_t         last_id,
  output word_t         last_data
);
  seq_state_t st;
  fin_t       fin_q;
  logic       empty_bit;

  assign empty_bit = port_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      fin_q     <= FIN_NONE;
      last_id   <= '0;
      last_data <= '0;
    end else begin
      fin_q <= FIN_NONE;
      case (st)
        S_IDLE: if (start) st <= S_WAIT_MSG;
        S_WAIT_MSG: if (port_fin) begin
          if (!empty_bit) st <= S_GET_ID;
          else if (expired) begin
            st    <= S_IDLE;
            fin_q <= FIN_TMO;
          end
        end
        S_GET_ID: if (port_fin) begin
          last_id <= port_data;
          st      <= S_GET_DATA;
        end
        S_GET_DATA: if (port_fin) begin
          last_data <= port_data;
          st        <= S_ACK_LO;
        end
        S_ACK_LO: if (port_fin) st <= S_WAIT_CLR;
        S_WAIT_CLR: if (port_fin) begin
          if (empty_bit) st <= S_ACK_HI;
          else if (expired) begin
            st    <= S_IDLE;
            fin_q <= FIN_TMO;
          end
        end
        S_ACK_HI: if (port_fin) begin
          if (last_id == ID_DONE) begin
            st    <= S_IDLE;
            fin_q <= FIN_OK;
          end else if (last_id == ID_FAIL) begin
            st    <= S_IDLE;
            fin_q <= FIN_ERR;
          end else begin
            st <= S_WAIT_MSG;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    go_write = 1'b0;
    go_wdata = '0;
    go_addr  = ST_ADDR;
    case (st)
      S_GET_ID:   go_addr = ID_ADDR;
      S_GET_DATA: go_addr = DAT_ADDR;
      S_ACK_LO: begin
        go_addr  = ACK_ADDR;
        go_write = 1'b1;
      end
      S_ACK_HI: begin
        go_addr  = ACK_ADDR;
        go_write = 1'b1;
        go_wdata = 16'h0001;
      end
      default: go_addr = ST_ADDR;
    endcase
  end

  assign go       = (st != S_IDLE) && port_idle;
  assign waiting  = (st == S_WAIT_MSG) || (st == S_WAIT_CLR);
  assign busy     = (st != S_IDLE);
  assign fin_kind = fin_q;
endmodule

// File: rtl/phy_mbox_reader.sv
module phy_mbox_reader
  import phy_mbox_pkg::*;
#(
  parameter int unsigned AW          = 24,
  parameter int unsigned TIMEOUT_CYC = 100_000_000,
  parameter int unsigned STATUS_IDX  = 32'hD0004,
  parameter int unsigned ACK_IDX     = 32'hD0031,
  parameter int unsigned ID_IDX      = 32'hD0032,
  parameter int unsigned DATA_IDX    = 32'hD0034,
  parameter logic [15:0] ID_DONE     = 16'h0007,
  parameter logic [15:0] ID_FAIL     = 16'h00FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          timeout,
  output logic [15:0]   last_id,
  output logic [15:0]   last_data,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_write,
  output logic [AW-1:0] req_addr,
  output logic [15:0]   req_wdata,
  input  logic          rsp_valid,
  input  logic [15:0]   rsp_rdata
);
  localparam logic [AW-1:0] ST_ADDR  = AW'(STATUS_IDX << 1);
  localparam logic [AW-1:0] ACK_ADDR = AW'(ACK_IDX << 1);
  localparam logic [AW-1:0] ID_ADDR  = AW'(ID_IDX << 1);
  localparam logic [AW-1:0] DAT_ADDR = AW'(DATA_IDX << 1);

  logic          go, go_write, port_idle, port_fin, waiting, expired;
  logic [AW-1:0] go_addr;
  word_t         go_wdata, port_data;
  fin_t          fin_kind;

  phy_mbox_seq #(
    .AW(AW), .ST_ADDR(ST_ADDR), .ACK_ADDR(ACK_ADDR), .ID_ADDR(ID_ADDR),
    .DAT_ADDR(DAT_ADDR), .ID_DONE(ID_DONE), .ID_FAIL(ID_FAIL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .port_idle(port_idle), .port_fin(port_fin), .port_data(port_data),
    .expired(expired), .go(go), .go_write(go_write), .go_addr(go_addr),
    .go_wdata(go_wdata), .waiting(waiting), .busy(busy),
    .fin_kind(fin_kind), .last_id(last_id), .last_data(last_data)
  );

  phy_mbox_port #(.AW(AW)) u_port (
    .clk(clk), .rst_n(rst_n), .go(go), .go_write(go_write),
    .go_addr(go_addr), .go_wdata(go_wdata), .idle(port_idle),
    .fin(port_fin), .fin_data(port_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  phy_mbox_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(waiting), .expired(expired)
  );

  assign done    = (fin_kind != FIN_NONE);
  assign pass    = (fin_kind == FIN_OK);
  assign timeout = (fin_kind == FIN_TMO);
endmodule

// File: rtl/phy_mbox_reader_chk.sv
module phy_mbox_reader_chk #(
  parameter int unsigned AW      = 24,
  parameter int unsigned ACK_IDX = 32'hD0031
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          timeout,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [15:0]   req_wdata
);
  localparam logic [AW-1:0] ACK_A = AW'(ACK_IDX << 1);

  assert_quiet_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_ack_only_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> (req_addr == ACK_A && (req_wdata == 16'h0000 || req_wdata == 16'h0001)));

  assert_pass_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (done && !timeout));

  assert_tmo_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (done && !pass));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)));
endmodule

bind phy_mbox_reader phy_mbox_reader_chk #(.AW(AW), .ACK_IDX(ACK_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .pass(pass), .timeout(timeout), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata)
);

// File: tb/sim_phy_mbox_reader.sv
module sim_phy_mbox_reader;
  localparam int AW  = 24;
  localparam int TMO = 40;
  localparam logic [AW-1:0] A_ST  = 24'h1A0008;
  localparam logic [AW-1:0] A_ACK = 24'h1A0062;
  localparam logic [AW-1:0] A_ID  = 24'h1A0064;
  localparam logic [AW-1:0] A_DAT = 24'h1A0068;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, pass, timeout, req_valid, req_write;
  logic req_ready = 1;
  logic [15:0] last_id, last_data, req_wdata;
  logic [AW-1:0] req_addr;
  logic rsp_valid = 0;
  logic [15:0] rsp_rdata = 0;

  always #4 clk = ~clk;

  phy_mbox_reader #(.AW(AW), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .pass(pass), .timeout(timeout), .last_id(last_id), .last_data(last_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic p;
    logic t;
    logic [15:0] id;
    logic [15:0] dat;
    string tag;
  } exp_t;
  exp_t sbq[$];

  // mailbox model
  localparam int M_EMPTY = 0, M_FULL = 1, M_DRAIN = 2, M_WAITHI = 3;
  int mstate = M_EMPTY, mcnt = 0;
  logic [15:0] mq_id[$], mq_dat[$];
  logic [15:0] cur_id = 0, cur_dat = 0;
  bit seen_id = 0, seen_dat = 0;
  bit stuck = 0, model_reset = 0, stray = 0;
  logic [7:0] lfsr = 8'h5A;

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    req_ready <= lfsr[0] | lfsr[2];
    rsp_valid <= 1'b0;
    if (model_reset) begin
      mstate = M_EMPTY; mcnt = 0;
    end else begin
      case (mstate)
        M_EMPTY: if (mcnt != 0) mcnt--;
                 else if (mq_id.size() > 0) begin
                   cur_id = mq_id.pop_front(); cur_dat = mq_dat.pop_front();
                   seen_id = 0; seen_dat = 0; mstate = M_FULL;
                 end
        M_DRAIN: if (!stuck) begin
                   if (mcnt == 0) mstate = M_WAITHI; else mcnt--;
                 end
        default: ;
      endcase
    end
    if (stray) begin
      rsp_valid <= 1'b1; rsp_rdata <= 16'h0000;
    end
    if (req_valid && req_ready) begin
      if (!req_write) begin
        rsp_valid <= 1'b1;
        if (req_addr == A_ST) rsp_rdata <= {15'b0, (mstate == M_EMPTY || mstate == M_WAITHI)};
        else if (req_addr == A_ID) begin
          check(mstate == M_FULL, "R3 id read with no message", mstate, M_FULL);
          seen_id = 1; rsp_rdata <= cur_id;
        end else if (req_addr == A_DAT) begin
          check(seen_id, "R3 data read before id", 0, 1);
          seen_dat = 1; rsp_rdata <= cur_dat;
        end else check(0, "R2 read address", req_addr, A_ST);
      end else begin
        if (req_addr == A_ACK && req_wdata == 16'h0000) begin
          check(mstate == M_FULL && seen_id && seen_dat, "R4 ack-low before id/data read", mstate, M_FULL);
          mstate = M_DRAIN; mcnt = 3;
        end else if (req_addr == A_ACK && req_wdata == 16'h0001) begin
          check(mstate == M_WAITHI, "R4 ack-high before empty", mstate, M_WAITHI);
          mstate = M_EMPTY; mcnt = 2;
        end else check(0, "R4 stray write", {8'h0, req_addr}, {8'h0, A_ACK});
      end
    end
  end

  // scoreboard monitor
  bit done_prev = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done_prev) check(!done, "R9 done longer than one cycle", done, 0);
      if (done) begin
        check(!busy, "R9 busy during done", busy, 0);
        if (sbq.size() == 0) check(0, "R11 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = sbq.pop_front();
          check(pass == e.p, {e.tag, " pass"}, pass, e.p);
          check(timeout == e.t, {e.tag, " timeout"}, timeout, e.t);
          check(last_id == e.id, {e.tag, " last_id"}, last_id, e.id);
          check(last_data == e.dat, {e.tag, " last_data"}, last_data, e.dat);
        end
      end
      done_prev = done;
    end
  end

  task automatic push_msg(input logic [15:0] id, input logic [15:0] d);
    mq_id.push_back(id); mq_dat.push_back(d);
  endtask

  task automatic expect_res(input logic p, input logic t, input logic [15:0] id,
                            input logic [15:0] d, input string tag);
    exp_t e;
    e.p = p; e.t = t; e.id = id; e.dat = d; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_quiet();
    while (sbq.size() != 0 || busy) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    check(!done && !pass && !timeout && !busy && !req_valid, "R1 outputs during reset",
          {done, pass, timeout, busy, req_valid}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!done && !busy && !req_valid, "R1 outputs after reset", {done, busy, req_valid}, 0);

    // R2 / R5: single completion message
    push_msg(16'h0007, 16'h1234);
    expect_res(1, 0, 16'h0007, 16'h1234, "R5 single completion");
    pulse_start();
    check(busy, "R2 busy after start", busy, 1);
    while (!req_valid) @(negedge clk);
    check(!req_write && req_addr == A_ST, "R2 first request is status read", {8'h0, req_addr}, {8'h0, A_ST});
    wait_quiet();

    // R7 / R11: progress messages, extra start while busy
    push_msg(16'h0010, 16'hAAAA);
    push_msg(16'h0020, 16'h5555);
    push_msg(16'h0007, 16'hBEEF);
    expect_res(1, 0, 16'h0007, 16'hBEEF, "R7 progress then completion");
    pulse_start();
    repeat (6) @(negedge clk);
    pulse_start();
    wait_quiet();
    repeat (60) @(negedge clk);
    check(!busy && !req_valid, "R11 start while busy ignored", busy, 0);

    // R6: failure identifier
    push_msg(16'h0003, 16'h0001);
    push_msg(16'h00FF, 16'hDEAD);
    expect_res(0, 0, 16'h00FF, 16'hDEAD, "R6 failure id");
    pulse_start();
    wait_quiet();

    // R8: no message, first wait expires; last values kept (R3)
    expect_res(0, 1, 16'h00FF, 16'hDEAD, "R8 first wait timeout");
    pulse_start();
    cyc = 0;
    while (!done) begin @(negedge clk); cyc++; end
    check(cyc >= TMO, "R8 timeout not before limit", cyc, TMO);
    wait_quiet();

    // R8: mailbox never empties after ack-low
    stuck = 1;
    push_msg(16'h0011, 16'h2222);
    expect_res(0, 1, 16'h0011, 16'h2222, "R8 second wait timeout");
    pulse_start();
    wait_quiet();
    stuck = 0;
    model_reset = 1;
    @(negedge clk);
    model_reset = 0;

    // R7: 0x0107 is not a completion identifier
    push_msg(16'h0107, 16'h1111);
    push_msg(16'h0007, 16'h7777);
    expect_res(1, 0, 16'h0007, 16'h7777, "R7 full 16-bit id compare");
    pulse_start();
    wait_quiet();

    // R11: start in the done cycle begins a new run
    push_msg(16'h0007, 16'hA5A5);
    push_msg(16'h0007, 16'h0001);
    expect_res(1, 0, 16'h0007, 16'hA5A5, "R11 first of back-to-back");
    expect_res(1, 0, 16'h0007, 16'h0001, "R11 start in done cycle");
    pulse_start();
    while (!done) @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
    check(busy, "R11 start in done cycle accepted", busy, 1);
    wait_quiet();

    // R10: response with no read outstanding is ignored
    stray = 1;
    @(negedge clk);
    stray = 0;
    repeat (8) @(negedge clk);
    check(!busy && !req_valid && !done, "R10 stray response ignored", {busy, req_valid, done}, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule